// File: doc/BRIEF.md
# Serial Receiver Wakeup Detector

This block sits beside a serial receiver core and holds the receiver in a sleep state until a chosen wakeup condition appears on the line. Software puts the receiver to sleep with a one-cycle strobe. Hardware then clears the sleep flag when the condition is met. While the receiver sleeps, its receive-data-full indication is hidden from the rest of the system, so characters meant for other stations pass unseen.

The wakeup condition is picked by an input. In address-mark mode, a received character whose most significant bit is 1 wakes the receiver. In idle-line mode, the receiver wakes after a full character time of consecutive 1s on the line. The receiver core supplies a bit-time strobe, a start-bit strobe and an end-of-frame strobe, and the block counts 1-valued bit times against these strobes. The count can start right after the start bit, which detects idle sooner but can be fooled by 1s at the end of a character. It can also start only after the stop bit, which avoids that false detection.

Top module: `rxw_wakeup`

## Requirements
- R1: After a synchronous reset, `asleep`, `wake_pulse` and `rx_full_out` are all 0.
- R2: With `wake_sel`=1 and `nine_bit`=0, a `frame_done` strobe while asleep clears `asleep` exactly when `rx_data_msb` (data bit 7) is 1. `rx_ninth` is ignored, and idle line time never wakes the receiver.
- R3: With `wake_sel`=1 and `nine_bit`=1, the address mark is `rx_ninth` (the ninth bit), and `rx_data_msb` is ignored.
- R4: A `sleep_set` strobe sets `asleep` on the same clock edge, and it stays set until a wakeup event occurs.
- R5: `wake_pulse` is 1 for exactly the one cycle in which hardware clears `asleep`.
- R6: `rx_full_out` equals `rx_full_in` whenever the updated sleep flag is 0, and it is 0 whenever the flag is 1.
- R7: With `wake_sel`=0 and `nine_bit`=0, the 10th consecutive 1-valued bit time (counted on `bit_tick`) wakes a sleeping receiver. The 9th does not.
- R8: With `nine_bit`=1, idle needs 11 consecutive 1-valued bit times.
- R9: Any bit time sampled as 0 on `rxd` restarts the idle count from zero.
- R10: With `idle_after_stop`=0, 1-valued data bits and the stop bit count toward idle. After a character of all 1s, a single further idle bit wakes the receiver.
- R11: With `idle_after_stop`=1, bit times from the start bit through the stop bit do not count. After a character of all 1s, ten more idle bits are needed in 8-bit mode.
- R12: If `sleep_set` coincides with a wakeup event, `asleep` stays 1 and `wake_pulse` stays 0.
- R13: Idle is signalled only when the count reaches the limit. If the line was already idle when the sleep strobe came, further 1s do not wake the receiver until a 0 bit restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_sel | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| idle_after_stop | input | 1 | 1 = count idle only after the stop bit, 0 = count from after the start bit |
| nine_bit | input | 1 | 1 = 9-bit characters, 0 = 8-bit characters |
| sleep_set | input | 1 | Software strobe that puts the receiver to sleep |
| bit_tick | input | 1 | One-cycle strobe at each bit time sample point |
| rxd | input | 1 | Sampled receive line level, valid on `bit_tick` |
| start_det | input | 1 | Strobe with the `bit_tick` of a start bit |
| frame_done | input | 1 | Strobe with the `bit_tick` of a stop bit |
| rx_data_msb | input | 1 | Data bit 7 of the completed character, valid on `frame_done` |
| rx_ninth | input | 1 | Ninth bit of the completed character, valid on `frame_done` |
| rx_full_in | input | 1 | Receive-data-full from the receiver core |
| asleep | output | 1 | Registered sleep flag |
| wake_pulse | output | 1 | Registered one-cycle hardware wakeup indication |
| rx_full_out | output | 1 | Registered, sleep-masked receive-data-full |

## Verification
Every output is a register that takes its new value on the same rising edge that samples the triggering strobe. A `sleep_set`, the wakeup-completing `bit_tick` or `frame_done` therefore shows on `asleep`, `wake_pulse` and `rx_full_out` one edge later, with no further latency. The bench drives inputs on falling edges. It compares the outputs with its model at the next falling edge, which is the first point where that edge's result is stable. Directed checks are placed right after the tick cycle that finishes each bit.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic {
    WAKE_ON_IDLE = 1'b0,
    WAKE_ON_MARK = 1'b1
  } wake_mode_e;

  // Bit times in one full character: start + data (+ ninth) + stop
  function automatic int unsigned char_bits(input int unsigned data_w, input logic ninth);
    return data_w + 2 + (ninth ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxw_frame_track.sv
module rxw_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic start_det,
  input  logic frame_done,
  input  logic after_stop,
  output logic hold_count
);

  logic in_frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
    end else if (bit_tick) begin
      if (frame_done)
        in_frame_q <= 1'b0;
      else if (start_det)
        in_frame_q <= 1'b1;
    end
  end

  // In stop-bit counting mode every bit time from start through stop is masked
  assign hold_count = after_stop & (in_frame_q | start_det | frame_done);

endmodule

// File: rtl/rxw_idle_count.sv
module rxw_idle_count #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 4)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rxd,
  input  logic hold,
  input  logic nine_bit,
  output logic idle_hit
);
  import rxw_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT8 = CNT_W'(char_bits(DATA_W, 1'b0));
  localparam logic [CNT_W-1:0] LIMIT9 = CNT_W'(char_bits(DATA_W, 1'b1));

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  assign limit = nine_bit ? LIMIT9 : LIMIT8;

  always_comb begin
    cnt_d = cnt_q;
    if (bit_tick) begin
      if (!rxd || hold)
        cnt_d = '0;
      else if (cnt_q < limit)
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // Fires once, on the bit time that brings the count up to the limit
  assign idle_hit = bit_tick & (cnt_d == limit) & (cnt_q != limit);

endmodule

// File: rtl/rxw_addr_mark.sv
module rxw_addr_mark (
  input  logic frame_done,
  input  logic nine_bit,
  input  logic rx_data_msb,
  input  logic rx_ninth,
  output logic mark_hit
);

  logic top_bit;

  assign top_bit  = nine_bit ? rx_ninth : rx_data_msb;
  assign mark_hit = frame_done & top_bit;

endmodule

// File: rtl/rxw_sleep_ctrl.sv
module rxw_sleep_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wake_sel,
  input  logic sleep_set,
  input  logic idle_hit,
  input  logic mark_hit,
  input  logic rx_full_in,
  output logic asleep,
  output logic wake_pulse,
  output logic rx_full_out
);
  import rxw_pkg::*;

  wake_mode_e mode;
  logic       cond, wake_ev, asleep_d;

  assign mode     = wake_mode_e'(wake_sel);
  assign cond     = (mode == WAKE_ON_MARK) ? mark_hit : idle_hit;
  assign wake_ev  = asleep & cond & ~sleep_set;
  assign asleep_d = sleep_set | (asleep & ~cond);

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep      <= 1'b0;
      wake_pulse  <= 1'b0;
      rx_full_out <= 1'b0;
    end else begin
      asleep      <= asleep_d;
      wake_pulse  <= wake_ev;
      rx_full_out <= rx_full_in & ~asleep_d;
    end
  end

endmodule

// File: rtl/rxw_wakeup.sv
module rxw_wakeup #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_sel,
  input  logic idle_after_stop,
  input  logic nine_bit,
  input  logic sleep_set,
  input  logic bit_tick,
  input  logic rxd,
  input  logic start_det,
  input  logic frame_done,
  input  logic rx_data_msb,
  input  logic rx_ninth,
  input  logic rx_full_in,
  output logic asleep,
  output logic wake_pulse,
  output logic rx_full_out
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 4);

  logic hold_count, idle_hit, mark_hit;

  rxw_frame_track u_frame (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .start_det  (start_det),
    .frame_done (frame_done),
    .after_stop (idle_after_stop),
    .hold_count (hold_count)
  );

  rxw_idle_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .rxd      (rxd),
    .hold     (hold_count),
    .nine_bit (nine_bit),
    .idle_hit (idle_hit)
  );

  rxw_addr_mark u_mark (
    .frame_done  (frame_done),
    .nine_bit    (nine_bit),
    .rx_data_msb (rx_data_msb),
    .rx_ninth    (rx_ninth),
    .mark_hit    (mark_hit)
  );

  rxw_sleep_ctrl u_sleep (
    .clk         (clk),
    .rst         (rst),
    .wake_sel    (wake_sel),
    .sleep_set   (sleep_set),
    .idle_hit    (idle_hit),
    .mark_hit    (mark_hit),
    .rx_full_in  (rx_full_in),
    .asleep      (asleep),
    .wake_pulse  (wake_pulse),
    .rx_full_out (rx_full_out)
  );

endmodule

// File: rtl/rxw_wakeup_chk.sv
module rxw_wakeup_chk (
  input logic clk,
  input logic rst,
  input logic wake_sel,
  input logic sleep_set,
  input logic bit_tick,
  input logic rxd,
  input logic frame_done,
  input logic asleep,
  input logic wake_pulse,
  input logic rx_full_out
);

  a_r4_set_sleeps: assert property (@(posedge clk) disable iff (rst)
    sleep_set |=> asleep);

  a_r4_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(sleep_set));

  a_r5_pulse_on_fall: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (!asleep && $past(asleep)));

  a_r6_full_hidden: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !rx_full_out);

  a_r2_mark_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && $past(wake_sel)) |-> $past(frame_done));

  a_r9_idle_needs_one: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && !$past(wake_sel)) |-> ($past(bit_tick) && $past(rxd)));

  a_r12_no_pulse_with_set: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_set) |-> !wake_pulse);

endmodule

bind rxw_wakeup rxw_wakeup_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wake_sel    (wake_sel),
  .sleep_set   (sleep_set),
  .bit_tick    (bit_tick),
  .rxd         (rxd),
  .frame_done  (frame_done),
  .asleep      (asleep),
  .wake_pulse  (wake_pulse),
  .rx_full_out (rx_full_out)
);

// File: tb/tb_rxw_wakeup.sv
`timescale 1ns/1ps
module tb_rxw_wakeup;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_sel = 0, idle_after_stop = 0, nine_bit = 0, sleep_set = 0;
  logic bit_tick = 0, rxd = 1, start_det = 0, frame_done = 0;
  logic rx_data_msb = 0, rx_ninth = 0, rx_full_in = 0;
  logic asleep, wake_pulse, rx_full_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  rxw_wakeup dut (
    .clk(clk), .rst(rst), .wake_sel(wake_sel), .idle_after_stop(idle_after_stop),
    .nine_bit(nine_bit), .sleep_set(sleep_set), .bit_tick(bit_tick), .rxd(rxd),
    .start_det(start_det), .frame_done(frame_done), .rx_data_msb(rx_data_msb),
    .rx_ninth(rx_ninth), .rx_full_in(rx_full_in), .asleep(asleep),
    .wake_pulse(wake_pulse), .rx_full_out(rx_full_out)
  );

  // Behavioural reference model
  int m_run = 0;
  bit m_framed = 0, m_sleep = 0, m_wake = 0, m_full = 0;

  always @(posedge clk) begin
    int need, nrun;
    bit mark, hit;
    if (rst) begin
      m_run = 0; m_framed = 0; m_sleep = 0; m_wake = 0; m_full = 0;
    end else begin
      need = nine_bit ? 11 : 10;
      nrun = m_run;
      if (bit_tick) begin
        if (rxd == 0) nrun = 0;
        else if (idle_after_stop && (m_framed || start_det || frame_done)) nrun = 0;
        else if (m_run < need) nrun = m_run + 1;
      end
      mark = frame_done && (nine_bit ? rx_ninth : rx_data_msb);
      hit  = wake_sel ? mark : (bit_tick && nrun == need && m_run != need);
      m_wake = m_sleep && hit && !sleep_set;
      if (sleep_set) m_sleep = 1;
      else if (hit) m_sleep = 0;
      m_full = rx_full_in && !m_sleep;
      m_run  = nrun;
      if (bit_tick && frame_done) m_framed = 0;
      else if (bit_tick && start_det) m_framed = 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 model asleep", asleep, m_sleep);
      check("R5 model wake_pulse", wake_pulse, m_wake);
      check("R6 model rx_full_out", rx_full_out, m_full);
    end
  end

  task automatic bit_time(input logic b, input logic st, input logic dn, input logic ss);
    for (int k = 0; k < 4; k++) begin
      rxd = b;
      bit_tick   = (k == 3);
      start_det  = st && (k == 3);
      frame_done = dn && (k == 3);
      sleep_set  = ss && (k == 3);
      @(negedge clk);
    end
    bit_tick = 0; start_det = 0; frame_done = 0; sleep_set = 0;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) bit_time(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic go_sleep();
    sleep_set = 1;
    @(negedge clk);
    sleep_set = 0;
  endtask

  task automatic frame(input logic [7:0] d, input logic ninth, input logic ss_at_end);
    bit_time(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_time(d[i], 1'b0, 1'b0, 1'b0);
    if (nine_bit) bit_time(ninth, 1'b0, 1'b0, 1'b0);
    rx_data_msb = d[7];
    rx_ninth    = ninth;
    bit_time(1'b1, 1'b0, 1'b1, ss_at_end);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset asleep", asleep, 1'b0);
    check("R1 reset wake_pulse", wake_pulse, 1'b0);
    check("R1 reset rx_full_out", rx_full_out, 1'b0);

    // Idle mode, 8-bit, count from start bit
    ones(12);
    go_sleep();
    check("R4 asleep after strobe", asleep, 1'b1);
    rx_full_in = 1;
    @(negedge clk);
    check("R6 full hidden while asleep", rx_full_out, 1'b0);
    ones(12);
    check("R13 saturated idle does not wake", asleep, 1'b1);
    bit_time(1'b0, 1'b0, 1'b0, 1'b0);
    ones(9);
    check("R7 nine ones keep sleeping", asleep, 1'b1);
    ones(1);
    check("R7 tenth one wakes", asleep, 1'b0);
    check("R5 wake pulse", wake_pulse, 1'b1);
    check("R6 full passed when awake", rx_full_out, 1'b1);
    @(negedge clk);
    check("R5 pulse one cycle", wake_pulse, 1'b0);
    rx_full_in = 0;

    // Zero restarts count
    go_sleep();
    bit_time(1'b0, 1'b0, 1'b0, 1'b0);
    ones(6);
    bit_time(1'b0, 1'b0, 1'b0, 1'b0);
    ones(9);
    check("R9 zero restarts count", asleep, 1'b1);
    ones(1);
    check("R9 wake after restart", asleep, 1'b0);

    // False early idle when counting from start bit
    go_sleep();
    frame(8'hFF, 1'b0, 1'b0);
    check("R10 asleep after frame", asleep, 1'b1);
    ones(1);
    check("R10 early idle wake", asleep, 1'b0);

    // Count only after stop bit
    idle_after_stop = 1;
    go_sleep();
    frame(8'hFF, 1'b0, 1'b0);
    ones(9);
    check("R11 no early idle", asleep, 1'b1);
    ones(1);
    check("R11 wake after full idle", asleep, 1'b0);
    idle_after_stop = 0;

    // 9-bit idle length
    nine_bit = 1;
    go_sleep();
    bit_time(1'b0, 1'b0, 1'b0, 1'b0);
    ones(10);
    check("R8 ten ones not enough", asleep, 1'b1);
    ones(1);
    check("R8 eleventh wakes", asleep, 1'b0);

    // Address mark, 8-bit
    nine_bit = 0;
    wake_sel = 1;
    go_sleep();
    frame(8'h7F, 1'b1, 1'b0);
    check("R2 msb clear stays asleep", asleep, 1'b1);
    bit_time(1'b0, 1'b0, 1'b0, 1'b0);
    ones(14);
    check("R2 idle ignored in mark mode", asleep, 1'b1);
    frame(8'h80, 1'b0, 1'b0);
    check("R2 msb set wakes", asleep, 1'b0);
    check("R5 mark wake pulse", wake_pulse, 1'b1);

    // Address mark, 9-bit
    nine_bit = 1;
    go_sleep();
    frame(8'hFF, 1'b0, 1'b0);
    check("R3 bit7 ignored in 9-bit", asleep, 1'b1);
    frame(8'h00, 1'b1, 1'b0);
    check("R3 ninth bit wakes", asleep, 1'b0);

    // Sleep strobe beats a coinciding wakeup
    go_sleep();
    frame(8'h00, 1'b1, 1'b1);
    check("R12 asleep held", asleep, 1'b1);
    check("R12 no pulse", wake_pulse, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule